// File: doc/BRIEF.md
# Serial Flash Status Register Unit

This block is the device-side status and write-protection logic of a serial NOR flash. It takes the host's chip select, serial clock and serial data input, decodes the status-related opcodes, and keeps the 8-bit status byte. The byte holds the busy flag, the write-enable latch, three block-protect bits, an error flag and a status-write lock bit. A read-status command returns this byte on the serial output, and it keeps returning it for as long as chip select stays low. The read works even while an operation is running.

The array controller beside it asks for a go or no-go decision on each page-program, sector-erase or chip-erase request. The block grants or denies the request from the write-enable latch, the block-protect bits and a protected-target flag that the controller computes. On a grant it raises the busy flag for a modelled, parameterised number of cycles. The controller reports pass or fail at the end of the operation, and this sets the error flag.

The serial pins are oversampled on the system clock. Chip select, serial clock and data pass through a synchroniser of configurable depth. Bits are taken on rising serial-clock edges, MSB first, in SPI mode 0.

Top module: `sflash_status_unit`

## Requirements
- R1: The status byte is, from bit 7 down: SRWD, error, constant 0, BP2, BP1, BP0, WEL, WIP.
- R2: After opcode 0x05, the status byte is driven on `so_o`, MSB first, with each bit changing after a falling serial-clock edge. It repeats byte after byte while chip select stays low, and each repetition is freshly loaded. `so_o` is 0 whenever chip select is high.
- R3: The status can be read while WIP is 1. Every other opcode is ignored while WIP is 1.
- R4: Opcode 0x06 sets WEL and opcode 0x04 clears it. Each takes effect only if chip select rises after exactly 8 bits.
- R5: Opcode 0x01 followed by one data byte, with WEL at 1 and chip select rising after exactly 16 bits, loads SRWD from data bit 7 and BP2..BP0 from data bits 4..2, ignores the other data bits, and starts a busy cycle. With any other bit count the command is discarded and WEL is kept.
- R6: With WEL at 0, a status write or a program/erase request is ignored: no register change, no busy, no grant and no deny.
- R7: When SRWD is 1 and `wp_n_i` is low, a status write is rejected. SRWD and BP are unchanged, WEL is cleared and no busy cycle starts. With `wp_n_i` high the write proceeds.
- R8: A chip erase (`op_kind_i` = 2) is granted only when BP2..BP0 are all 0. Otherwise it is denied and WEL is cleared. Kind 3 is always denied.
- R9: A page program (kind 0) or sector erase (kind 1) is granted when `op_prot_i` is 0. It is denied, with WEL cleared, when `op_prot_i` is 1. Grant and deny are one-cycle pulses in the cycle after the request.
- R10: WIP (`busy_o`) is 1 for exactly BUSY_CYCLES clock cycles, starting the cycle after acceptance. WEL is cleared when the busy cycle completes, and requests during busy get no grant and no deny.
- R11: At the end of each program or erase, the error flag takes the value of `op_fail_i` sampled in the last busy cycle. A status-write completion leaves it unchanged, and a new request is still granted while it is 1.
- R12: Reset clears WIP, WEL and the error flag and loads SRWD and BP from the parameter NV_RESET (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Serial chip select, active low |
| sck_i | input | 1 | Serial clock from the host |
| si_i | input | 1 | Serial data from the host |
| so_o | output | 1 | Serial data to the host |
| wp_n_i | input | 1 | Hardware write-protect input, active low |
| op_req_i | input | 1 | Program/erase request pulse from the array controller |
| op_kind_i | input | 2 | 0 page program, 1 sector erase, 2 chip erase, 3 reserved |
| op_prot_i | input | 1 | Target of a program/sector erase lies in the protected area |
| op_fail_i | input | 1 | Result of the running program/erase, 1 = failed |
| op_grant_o | output | 1 | Request granted (one-cycle pulse) |
| op_deny_o | output | 1 | Request denied (one-cycle pulse) |
| busy_o | output | 1 | WIP flag |
| bp_o | output | 3 | Block-protect bits BP2..BP0 for area decoding |

## Verification
Some rules are checked in every cycle: the lock bits never change while the hardware lock holds, SRWD and BP change only through an accepted status write, busy never starts unless WEL was set, a chip-erase grant never appears with nonzero BP, and the error flag moves only at a program/erase completion. Other behaviour shows only in the bench scenarios. This covers the serial bit ordering and byte repetition of the read, the discard of wrong-length commands, the exact busy duration, and the end-to-end effect of each write on the byte read back afterwards.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
   localparam logic [7:0] OPC_WREN = 8'h06;
   localparam logic [7:0] OPC_WRDI = 8'h04;
   localparam logic [7:0] OPC_RDSR = 8'h05;
   localparam logic [7:0] OPC_WRSR = 8'h01;

   localparam logic [1:0] KIND_PROG = 2'd0;
   localparam logic [1:0] KIND_SECT = 2'd1;
   localparam logic [1:0] KIND_CHIP = 2'd2;

   localparam int unsigned BP_W = 3;
   localparam int unsigned NV_W = BP_W + 1;
endpackage

// File: rtl/sfsr_spi_front.sv
module sfsr_spi_front import sfsr_pkg::*; #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n_i,
   input  logic             sck_i,
   input  logic             si_i,
   input  logic [7:0]       status_i,
   output logic             so_o,
   output logic             cs_rise_o,
   output logic [CNT_W-1:0] bits_o,
   output logic [7:0]       opcode_o,
   output logic [NV_W-1:0]  nv_data_o
);
   localparam logic [CNT_W-1:0] BITS_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 5) begin : g_bad_cnt
         $error("CNT_W must hold a count of at least 16 bits");
      end
   endgenerate

   logic cs_s, sck_s, si_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign cs_s  = cs_n_i;
         assign sck_s = sck_i;
         assign si_s  = si_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] cs_p, sck_p, si_p;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_p  <= '1;
               sck_p <= '0;
               si_p  <= '0;
            end else begin
               cs_p[0]  <= cs_n_i;
               sck_p[0] <= sck_i;
               si_p[0]  <= si_i;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  cs_p[i]  <= cs_p[i-1];
                  sck_p[i] <= sck_p[i-1];
                  si_p[i]  <= si_p[i-1];
               end
            end
         end
         assign cs_s  = cs_p[SYNC_STAGES-1];
         assign sck_s = sck_p[SYNC_STAGES-1];
         assign si_s  = si_p[SYNC_STAGES-1];
      end
   endgenerate

   logic       cs_q, sck_q, rd_mode, so_q;
   logic [6:0] in_sh, snap;
   logic [2:0] out_idx;
   logic [CNT_W-1:0] bits_q;
   logic [7:0] opc_q;
   logic [NV_W-1:0] nv_q;

   wire rise_w = ~cs_s & sck_s & ~sck_q;
   wire fall_w = ~cs_s & ~sck_s & sck_q;
   wire [7:0] byte_w = {in_sh, si_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q <= 1'b1;
         sck_q <= 1'b0;
      end else begin
         cs_q <= cs_s;
         sck_q <= sck_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_sh <= '0; snap <= '0; out_idx <= '0; bits_q <= '0;
         opc_q <= '0; nv_q <= '0; rd_mode <= 1'b0; so_q <= 1'b0;
      end else if (cs_s) begin
         bits_q  <= '0;
         rd_mode <= 1'b0;
         out_idx <= '0;
         so_q    <= 1'b0;
      end else begin
         if (rise_w) begin
            in_sh <= byte_w[6:0];
            if (bits_q != BITS_MAX) bits_q <= bits_q + 1'b1;
            if (bits_q == CNT_W'(7)) begin
               opc_q   <= byte_w;
               rd_mode <= (byte_w == OPC_RDSR);
            end
            if (bits_q == CNT_W'(15)) nv_q <= {byte_w[7], byte_w[4:2]};
         end
         if (fall_w && rd_mode) begin
            out_idx <= out_idx + 1'b1;
            if (out_idx == 3'd0) begin
               so_q <= status_i[7];
               snap <= status_i[6:0];
            end else begin
               so_q <= snap[6];
               snap <= {snap[5:0], 1'b0};
            end
         end
      end
   end

   assign so_o      = so_q;
   assign cs_rise_o = cs_s & ~cs_q;
   assign bits_o    = bits_q;
   assign opcode_o  = opc_q;
   assign nv_data_o = nv_q;

   assert_so_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> (so_o == 1'b0));
   assert_rd_opcode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_mode) |-> (opcode_o == OPC_RDSR));
endmodule

// File: rtl/sfsr_guard.sv
module sfsr_guard import sfsr_pkg::*; #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             evt_i,
   input  logic [7:0]       opcode_i,
   input  logic [CNT_W-1:0] bits_i,
   input  logic             wel_i,
   input  logic             busy_i,
   input  logic             srwd_i,
   input  logic             wp_n_i,
   input  logic [BP_W-1:0]  bp_i,
   input  logic             op_req_i,
   input  logic [1:0]       op_kind_i,
   input  logic             op_prot_i,
   output logic             set_wel_o,
   output logic             clr_wel_o,
   output logic             wrsr_ok_o,
   output logic             wrsr_rej_o,
   output logic             pe_grant_o,
   output logic             pe_deny_o
);
   logic cmd_ok, byte_cmd, wrsr_try, hw_lock, pe_try, allow;

   always_comb begin
      cmd_ok     = evt_i & ~busy_i;
      byte_cmd   = cmd_ok & (bits_i == CNT_W'(8));
      set_wel_o  = byte_cmd & (opcode_i == OPC_WREN);
      clr_wel_o  = byte_cmd & (opcode_i == OPC_WRDI);
      wrsr_try   = cmd_ok & (bits_i == CNT_W'(16)) & (opcode_i == OPC_WRSR) & wel_i;
      hw_lock    = srwd_i & ~wp_n_i;
      wrsr_ok_o  = wrsr_try & ~hw_lock;
      wrsr_rej_o = wrsr_try & hw_lock;
      pe_try     = op_req_i & ~busy_i & wel_i & ~wrsr_ok_o;
      unique case (op_kind_i)
         KIND_PROG, KIND_SECT: allow = ~op_prot_i;
         KIND_CHIP:            allow = (bp_i == '0);
         default:              allow = 1'b0;
      endcase
      pe_grant_o = pe_try & allow;
      pe_deny_o  = pe_try & ~allow;
   end
endmodule

// File: rtl/sfsr_busy_timer.sv
module sfsr_busy_timer #(
   parameter int unsigned BUSY_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);

   generate
      if (BUSY_CYCLES < 1) begin : g_bad_len
         $error("BUSY_CYCLES must be at least 1");
      end
   endgenerate

   logic          busy_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= CW'(BUSY_CYCLES - 1);
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q & (cnt_q == '0);

   assert_end_via_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(done_o));
   assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !start_i);
endmodule

// File: rtl/sflash_status_unit.sv
module sflash_status_unit import sfsr_pkg::*; #(
   parameter int unsigned    BUSY_CYCLES = 1000,
   parameter int unsigned    SYNC_STAGES = 2,
   parameter logic [NV_W-1:0] NV_RESET   = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_n_i,
   input  logic            sck_i,
   input  logic            si_i,
   output logic            so_o,
   input  logic            wp_n_i,
   input  logic            op_req_i,
   input  logic [1:0]      op_kind_i,
   input  logic            op_prot_i,
   input  logic            op_fail_i,
   output logic            op_grant_o,
   output logic            op_deny_o,
   output logic            busy_o,
   output logic [BP_W-1:0] bp_o
);
   localparam int unsigned CNT_W = 5;

   generate
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   logic             srwd_q, wel_q, err_q, pe_run_q;
   logic [BP_W-1:0]  bp_q;
   logic [1:0]       gkind_q;
   logic [7:0]       status;
   logic             evt, busy, done;
   logic [CNT_W-1:0] bits;
   logic [7:0]       opcode;
   logic [NV_W-1:0]  nv_data;
   logic set_wel, clr_wel, wrsr_ok, wrsr_rej, pe_grant, pe_deny;

   assign status = {srwd_q, err_q, 1'b0, bp_q, wel_q, busy};

   sfsr_spi_front #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_front (
      .clk, .rst_n, .cs_n_i, .sck_i, .si_i,
      .status_i(status), .so_o, .cs_rise_o(evt), .bits_o(bits),
      .opcode_o(opcode), .nv_data_o(nv_data));

   sfsr_guard #(.CNT_W(CNT_W)) u_guard (
      .evt_i(evt), .opcode_i(opcode), .bits_i(bits), .wel_i(wel_q),
      .busy_i(busy), .srwd_i(srwd_q), .wp_n_i, .bp_i(bp_q),
      .op_req_i, .op_kind_i, .op_prot_i,
      .set_wel_o(set_wel), .clr_wel_o(clr_wel), .wrsr_ok_o(wrsr_ok),
      .wrsr_rej_o(wrsr_rej), .pe_grant_o(pe_grant), .pe_deny_o(pe_deny));

   sfsr_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
      .clk, .rst_n, .start_i(wrsr_ok | pe_grant), .busy_o(busy), .done_o(done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srwd_q <= NV_RESET[NV_W-1];
         bp_q   <= NV_RESET[BP_W-1:0];
         wel_q  <= 1'b0; err_q <= 1'b0; pe_run_q <= 1'b0;
         op_grant_o <= 1'b0; op_deny_o <= 1'b0; gkind_q <= '0;
      end else begin
         if (wrsr_ok) begin
            srwd_q <= nv_data[NV_W-1];
            bp_q   <= nv_data[BP_W-1:0];
         end
         if (pe_grant)     pe_run_q <= 1'b1;
         else if (wrsr_ok) pe_run_q <= 1'b0;
         if (done && pe_run_q) err_q <= op_fail_i;
         if (done || wrsr_rej || pe_deny) wel_q <= 1'b0;
         else if (set_wel)                wel_q <= 1'b1;
         else if (clr_wel)                wel_q <= 1'b0;
         op_grant_o <= pe_grant;
         op_deny_o  <= pe_deny;
         gkind_q    <= op_kind_i;
      end
   end

   assign busy_o = busy;
   assign bp_o   = bp_q;

   assert_hw_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(srwd_q) && !$past(wp_n_i)) |-> (srwd_q == $past(srwd_q) && bp_q == $past(bp_q)));
   assert_nv_only_wrsr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({srwd_q, bp_q}) |-> $past(wrsr_ok));
   assert_busy_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wel_q));
   assert_wel_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel_q) |-> $past(set_wel));
   assert_ce_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_grant_o && gkind_q == KIND_CHIP) |-> (bp_q == '0));
   assert_err_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(err_q) |-> $past(done && pe_run_q));
   assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({op_grant_o, op_deny_o}));
endmodule

// File: tb/sflash_status_unit_bench.sv
module sflash_status_unit_bench;
   localparam int BUSY = 1000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
   logic op_req = 1'b0, op_prot = 1'b0, op_fail = 1'b0;
   logic [1:0] op_kind = 2'd0;
   logic so, grant, deny, busy;
   logic [2:0] bp;
   int n_tests = 0, n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sflash_status_unit #(.BUSY_CYCLES(BUSY)) u_sflash_status_unit (
      .clk, .rst_n, .cs_n_i(cs_n), .sck_i(sck), .si_i(si), .so_o(so),
      .wp_n_i(wp_n), .op_req_i(op_req), .op_kind_i(op_kind), .op_prot_i(op_prot),
      .op_fail_i(op_fail), .op_grant_o(grant), .op_deny_o(deny),
      .busy_o(busy), .bp_o(bp));

   // status byte {SRWD, ERR, 0, BP2..BP0, WEL, WIP}; WRSR input {data, wp_n}
   localparam logic [8:0] WR_VEC [7] = '{
      {8'h1C, 1'b1}, {8'hFF, 1'b1}, {8'h00, 1'b0}, {8'h08, 1'b1},
      {8'h84, 1'b0}, {8'h10, 1'b0}, {8'h00, 1'b1}};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bit_x(input logic b, output logic o);
      si = b;
      repeat (4) @(negedge clk);
      o = so;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
   endtask

   task automatic cs_lo;
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic cs_hi;
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic send_bits(input logic [15:0] v, input int n);
      logic d;
      for (int i = n - 1; i >= 0; i--) bit_x(v[i], d);
   endtask

   task automatic cmd(input logic [15:0] v, input int n);
      cs_lo; send_bits(v, n); cs_hi;
   endtask

   task automatic get_byte(output logic [7:0] s);
      logic d;
      for (int i = 7; i >= 0; i--) begin bit_x(1'b0, d); s[i] = d; end
   endtask

   task automatic rdsr(output logic [7:0] s);
      cs_lo; send_bits(16'h05, 8); get_byte(s); cs_hi;
   endtask

   task automatic wait_idle;
      int n = 0;
      while (busy && n < 5000) begin @(negedge clk); n++; end
   endtask

   task automatic op(input logic [1:0] k, input logic p, output logic g, output logic dn);
      op_kind = k; op_prot = p; op_req = 1'b1;
      @(negedge clk);
      op_req = 1'b0;
      g = grant; dn = deny;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] s, s2;
      logic g, dn, esrwd, locked;
      logic [2:0] ebp;
      int cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk("R12 so", so, 0); chk("R12 busy", busy, 0);
      chk("R12 bp", bp, 0); chk("R12 grant/deny", {grant, deny}, 0);
      rdsr(s); chk("R12 status", s, 8'h00);

      // table: status writes under the hardware lock (R1 R5 R7)
      esrwd = 1'b0; ebp = 3'd0;
      for (int i = 0; i < 7; i++) begin
         locked = esrwd & ~WR_VEC[i][0];
         wp_n = WR_VEC[i][0];
         cmd(16'h06, 8);
         cmd({8'h01, WR_VEC[i][8:1]}, 16);
         chk("R5/R7 busy start", busy, !locked);
         wait_idle;
         if (!locked) begin esrwd = WR_VEC[i][8]; ebp = WR_VEC[i][5:3]; end
         rdsr(s);
         chk("R1/R5/R7 readback", s, {esrwd, 2'b00, ebp, 2'b00});
      end
      wp_n = 1'b1;

      // R4 enable/disable and exact length
      cmd(16'h06, 8); rdsr(s); chk("R4 wren", s, 8'h02);
      cmd(16'h04, 8); rdsr(s); chk("R4 wrdi", s, 8'h00);
      cmd({7'h0, 8'h06, 1'b0}, 9); rdsr(s); chk("R4 nine bits", s, 8'h00);

      // R2 repeated bytes in one select
      cmd(16'h06, 8);
      cs_lo; send_bits(16'h05, 8); get_byte(s); get_byte(s2); cs_hi;
      chk("R2 first byte", s, 8'h02); chk("R2 second byte", s2, 8'h02);
      cmd(16'h04, 8);

      // R6 ignored without WEL
      cmd({8'h01, 8'h1C}, 16);
      chk("R6 wrsr busy", busy, 0); chk("R6 wrsr bp", bp, 0);
      op(2'd0, 1'b0, g, dn);
      chk("R6 op pulses", {g, dn}, 0); chk("R6 op busy", busy, 0);

      // R5 wrong length discarded, WEL kept
      cmd(16'h06, 8);
      cs_lo; send_bits(16'h01, 8); send_bits(16'h0E, 7); cs_hi;
      chk("R5 short busy", busy, 0);
      rdsr(s); chk("R5 short kept", s, 8'h02);
      cmd(16'h04, 8);

      // R3 read during busy, other opcodes ignored
      cmd(16'h06, 8);
      op(2'd0, 1'b0, g, dn); chk("R9 prog grant", g, 1);
      rdsr(s); chk("R3 read busy", s, 8'h03);
      cmd(16'h04, 8); rdsr(s); chk("R3 wrdi ignored", s, 8'h03);
      wait_idle; rdsr(s); chk("R10 wel cleared", s, 8'h00);

      // R10 exact busy length
      cmd(16'h06, 8);
      op(2'd1, 1'b0, g, dn); chk("R10 sect grant", g, 1);
      cnt = 0;
      while (busy && cnt < 5000) begin cnt++; @(negedge clk); end
      chk("R10 busy cycles", cnt, BUSY);

      // R9 protected target
      cmd(16'h06, 8);
      op(2'd0, 1'b1, g, dn); chk("R9 deny", {g, dn}, 2'b01);
      chk("R9 no busy", busy, 0);
      rdsr(s); chk("R9 wel cleared", s, 8'h00);

      // R8 chip erase gated by BP
      cmd(16'h06, 8); cmd({8'h01, 8'h04}, 16); wait_idle;
      chk("R8 bp set", bp, 3'b001);
      cmd(16'h06, 8);
      op(2'd2, 1'b0, g, dn); chk("R8 ce deny", {g, dn}, 2'b01);
      rdsr(s); chk("R8 after deny", s, 8'h04);
      cmd(16'h06, 8); cmd({8'h01, 8'h00}, 16); wait_idle;
      cmd(16'h06, 8);
      op(2'd3, 1'b0, g, dn); chk("R8 kind3 deny", {g, dn}, 2'b01);
      cmd(16'h06, 8);
      op(2'd2, 1'b0, g, dn); chk("R8 ce grant", {g, dn}, 2'b10);
      wait_idle;

      // R11 error flag
      op_fail = 1'b1;
      cmd(16'h06, 8); op(2'd0, 1'b0, g, dn); wait_idle;
      rdsr(s); chk("R11 err set", s, 8'h40);
      op_fail = 1'b0;
      cmd(16'h06, 8); cmd({8'h01, 8'h00}, 16); wait_idle;
      rdsr(s); chk("R11 wrsr keeps err", s, 8'h40);
      cmd(16'h06, 8); op(2'd1, 1'b0, g, dn); chk("R11 retry grant", g, 1);
      wait_idle; rdsr(s); chk("R11 err cleared", s, 8'h00);

      // R12 volatile bits cleared by reset
      cmd(16'h06, 8);
      rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
      rdsr(s); chk("R12 after reset", s, 8'h00);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule